// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is a memory-mapped SPI master for a processor bus. Software programs a control word and queues outgoing words in a transmit FIFO. The block shifts each word out on `mosi` and samples `miso` into a receive FIFO. Software then drains the receive FIFO through a data register. The SCK rate is set by a build parameter and cannot be changed at run time. Both FIFOs share one depth parameter, and the word width is also a parameter (8 bits by default).

Software drives the slave-select lines directly from a register: all ones deselects every slave, and clearing a single bit selects that slave. A transmit-hold bit lets software fill the FIFO without starting the bus, then release the whole burst at once so the words go out back to back. A loopback mode feeds the shift output to its own input for self-test, and the shift order can be switched to least-significant bit first. An interrupt section has a global gate, sticky write-one-to-clear status bits and per-bit enables. A keyed write to a reset register returns the whole block to its reset state.

Top module: `mmspi_master`

## Requirements
- R1: After `rst_n` is released:
  - control (0x60) reads 0;
  - status (0x64) reads 0x05 (bit0 receive empty and bit2 transmit empty set; bit1 receive full, bit3 transmit full and bit4 mode fault clear);
  - `ss_n` is all ones;
  - `irq` is 0;
  - `sck` is 0.
- R2: Writing exactly 0x0000000A to offset 0x40 restores the R1 state in the next cycle: both FIFOs empty, any transfer aborted, global enable (0x1C) reading 0. Writing any other value to 0x40 changes nothing.
- R3: Status bit3 (transmit full) is set exactly when the transmit FIFO holds DEPTH words. It is clear after DEPTH-1 writes to offset 0x68 and set after DEPTH writes.
- R4: SCK stays idle and no word leaves the transmit FIFO unless three control bits all allow it: bit1 (enable) set, bit2 (master) set and bit8 (hold) clear.
- R5: When R4's bits release a full FIFO, the words go out back to back. Each word takes 2·W·HALF_DIV clock cycles. Interrupt status bit2 sets at the edge 1 + DEPTH·2·W·HALF_DIV cycles after the edge that wrote the control register.
- R6: Control bit3 sets the SCK idle level. Control bit4 selects the SPI phase:
  - bit4 = 0: data is sampled on the leading edge and changed on the trailing edge.
  - bit4 = 1: data is changed on the leading edge and sampled on the trailing edge.
  A slave following that rule exchanges words correctly in all four modes.
- R7: With control bit9 = 0, bit W-1 of each word is shifted first on both `mosi` and `miso`. With bit9 = 1, bit 0 goes first, so the received word is the bit-reverse of what the slave sent MSB-first.
- R8: With control bit0 set, each received word equals the word sent and the level on `miso` has no effect.
- R9: Offset 0x70 drives `ss_n` bit for bit (bit i drives line i).
- R10: Writing control with bit5 set empties the transmit FIFO; writing it with bit6 set empties the receive FIFO. Both bits read back as 0.
- R11: Interrupt status (0x20) bits are sticky and each one is cleared by writing 1 to it:
  - bit2: the last queued word finishes while the transmit FIFO is empty;
  - bit4: the receive FIFO becomes full;
  - bit5: a received word is dropped because the receive FIFO is full;
  - bit6: the transmit FIFO drains to DEPTH/2 words.
- R12: `irq` is 1 only when bit31 of offset 0x1C is set and some status bit whose enable bit at offset 0x28 is set is also 1.
- R13: Reading offset 0x6C with `bus_rd` removes the oldest received word. Reading it while the receive FIFO is empty returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops receive data) |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Interrupt request |
| sck | output | 1 | SPI clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | NSS | Slave-select lines, active low |

## Verification
The assertions assume that software does not change control bits 3, 4 and 9 while a word is shifting. They also assume at most one register access per cycle. The bench keeps to this by writing the mode only when the engine is idle, and by issuing every access as a one-cycle strobe. The bench's slave model follows the mode it was configured with, and it is enabled only after that mode is written, so the idle-level change of SCK is never mistaken for a data edge.

// File: rtl/mmspi_pkg.sv
package mmspi_pkg;
    // register byte offsets (software-visible map)
    localparam logic [7:0] A_GIE  = 8'h1C;
    localparam logic [7:0] A_ISR  = 8'h20;
    localparam logic [7:0] A_IER  = 8'h28;
    localparam logic [7:0] A_SRST = 8'h40;
    localparam logic [7:0] A_CTRL = 8'h60;
    localparam logic [7:0] A_STAT = 8'h64;
    localparam logic [7:0] A_TXD  = 8'h68;
    localparam logic [7:0] A_RXD  = 8'h6C;
    localparam logic [7:0] A_SSEL = 8'h70;

    localparam logic [31:0] SRST_KEY = 32'h0000_000A;

    // control bit positions
    localparam int C_LOOP  = 0;
    localparam int C_EN    = 1;
    localparam int C_MST   = 2;
    localparam int C_CPOL  = 3;
    localparam int C_CPHA  = 4;
    localparam int C_TXRST = 5;
    localparam int C_RXRST = 6;
    localparam int C_INH   = 8;
    localparam int C_LSB   = 9;
    localparam int NCTRL   = 10;

    // interrupt status bit positions
    localparam int I_TXEMPTY = 2;
    localparam int I_RXFULL  = 4;
    localparam int I_RXOVR   = 5;
    localparam int I_TXHALF  = 6;
    localparam int NIRQ      = 7;
endpackage

// File: rtl/mmspi_fifo.sv
module mmspi_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic          empty,
    output logic          full,
    output logic [CW-1:0] level
);
    localparam logic [CW-1:0] FULLV = CW'(DEPTH);
    localparam logic [AW-1:0] LASTP = AW'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           rd;
        logic [AW-1:0]           wr;
        logic [CW-1:0]           cnt;
    } fifo_t;

    fifo_t q, d;
    logic do_push, do_pop;

    always_comb begin
        d       = q;
        do_pop  = pop && (q.cnt != '0);
        do_push = push && ((q.cnt != FULLV) || do_pop);
        if (do_push) begin
            d.mem[q.wr] = din;
            d.wr        = (q.wr == LASTP) ? '0 : q.wr + 1'b1;
        end
        if (do_pop)
            d.rd = (q.rd == LASTP) ? '0 : q.rd + 1'b1;
        d.cnt = q.cnt + CW'(do_push) - CW'(do_pop);
        if (clr) begin
            d.rd  = '0;
            d.wr  = '0;
            d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign dout  = q.mem[q.rd];
    assign empty = (q.cnt == '0);
    assign full  = (q.cnt == FULLV);
    assign level = q.cnt;
endmodule

// File: rtl/mmspi_shifter.sv
module mmspi_shifter #(
    parameter int W        = 8,
    parameter int HALF_DIV = 4,
    localparam int HW      = $clog2(2 * W),
    localparam int DW      = $clog2(HALF_DIV + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         abort,
    input  logic         cpol,
    input  logic         cpha,
    input  logic         lsb,
    input  logic         loop,
    input  logic         go,
    input  logic         have_word,
    input  logic [W-1:0] word_in,
    input  logic         miso,
    output logic         take,
    output logic         done,
    output logic [W-1:0] rx_word,
    output logic         busy,
    output logic         sck,
    output logic         mosi
);
    localparam logic [DW-1:0] DIV_LAST  = DW'(HALF_DIV - 1);
    localparam logic [HW-1:0] HALF_LAST = HW'(2 * W - 1);

    typedef struct packed {
        logic          busy;
        logic [HW-1:0] h;
        logic [DW-1:0] div;
        logic [W-1:0]  tsr;
        logic [W-1:0]  rsr;
    } sh_t;

    sh_t q, d;
    logic half_end, samp, shft, last, in_bit;
    logic [W-1:0] rs_n;

    always_comb begin
        d        = q;
        take     = 1'b0;
        done     = 1'b0;
        mosi     = lsb ? q.tsr[0] : q.tsr[W-1];
        in_bit   = loop ? mosi : miso;
        half_end = q.busy && (q.div == DIV_LAST);
        samp     = half_end && (q.h[0] == cpha);
        shft     = half_end && (q.h[0] != cpha) && (q.h != '0);
        last     = half_end && (q.h == HALF_LAST);
        rs_n     = lsb ? {in_bit, q.rsr[W-1:1]} : {q.rsr[W-2:0], in_bit};
        rx_word  = samp ? rs_n : q.rsr;
        if (q.busy) begin
            d.div = half_end ? '0 : q.div + 1'b1;
            if (half_end) d.h = q.h + 1'b1;
        end
        if (samp) d.rsr = rs_n;
        if (shft) d.tsr = lsb ? {1'b0, q.tsr[W-1:1]} : {q.tsr[W-2:0], 1'b0};
        if (last) begin
            done   = 1'b1;
            d.busy = 1'b0;
        end
        if ((!q.busy || last) && go && have_word) begin
            take   = 1'b1;
            d.busy = 1'b1;
            d.h    = '0;
            d.div  = '0;
            d.tsr  = word_in;
        end
        if (abort) begin
            d    = '0;
            take = 1'b0;
            done = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy = q.busy;
    assign sck  = q.busy ? (cpol ^ q.h[0]) : cpol;
endmodule

// File: rtl/mmspi_master.sv
module mmspi_master #(
    parameter int W        = 8,
    parameter int DEPTH    = 16,
    parameter int HALF_DIV = 4,
    parameter int NSS      = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_wr,
    input  logic           bus_rd,
    input  logic [7:0]     bus_addr,
    input  logic [31:0]    bus_wdata,
    output logic [31:0]    bus_rdata,
    output logic           irq,
    output logic           sck,
    output logic           mosi,
    input  logic           miso,
    output logic [NSS-1:0] ss_n
);
    import mmspi_pkg::*;

    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] RX_NEAR = CW'(DEPTH - 1);
    localparam logic [CW-1:0] TX_MID  = CW'(DEPTH / 2 + 1);

    typedef struct packed {
        logic [NCTRL-1:0] ctrl;
        logic [NSS-1:0]   ss;
        logic             gie;
        logic [NIRQ-1:0]  ier;
        logic [NIRQ-1:0]  isr;
    } regs_t;

    localparam regs_t REGS_RST = '{ctrl: '0, ss: {NSS{1'b1}}, gie: 1'b0, ier: '0, isr: '0};

    regs_t regs_q, regs_d;

    logic soft_rst, wr_ctrl, tx_clr, rx_clr, tx_push, rx_pop, go;
    logic tx_empty, tx_full, rx_empty, rx_full, take, done, busy;
    logic [W-1:0] tx_head, rx_head, rx_word;
    logic [CW-1:0] tx_level, rx_level;
    logic [NIRQ-1:0] ev;

    // bus decode
    assign soft_rst = bus_wr && (bus_addr == A_SRST) && (bus_wdata == SRST_KEY);
    assign wr_ctrl  = bus_wr && (bus_addr == A_CTRL);
    assign tx_clr   = soft_rst || (wr_ctrl && bus_wdata[C_TXRST]);
    assign rx_clr   = soft_rst || (wr_ctrl && bus_wdata[C_RXRST]);
    assign tx_push  = bus_wr && (bus_addr == A_TXD);
    assign rx_pop   = bus_rd && (bus_addr == A_RXD);
    assign go       = regs_q.ctrl[C_EN] && regs_q.ctrl[C_MST] && !regs_q.ctrl[C_INH];

    mmspi_fifo #(.W(W), .DEPTH(DEPTH)) u_txf (
        .clk(clk), .rst_n(rst_n), .clr(tx_clr), .push(tx_push),
        .din(bus_wdata[W-1:0]), .pop(take), .dout(tx_head),
        .empty(tx_empty), .full(tx_full), .level(tx_level)
    );

    mmspi_fifo #(.W(W), .DEPTH(DEPTH)) u_rxf (
        .clk(clk), .rst_n(rst_n), .clr(rx_clr), .push(done),
        .din(rx_word), .pop(rx_pop), .dout(rx_head),
        .empty(rx_empty), .full(rx_full), .level(rx_level)
    );

    mmspi_shifter #(.W(W), .HALF_DIV(HALF_DIV)) u_sh (
        .clk(clk), .rst_n(rst_n), .abort(soft_rst),
        .cpol(regs_q.ctrl[C_CPOL]), .cpha(regs_q.ctrl[C_CPHA]),
        .lsb(regs_q.ctrl[C_LSB]), .loop(regs_q.ctrl[C_LOOP]),
        .go(go), .have_word(!tx_empty), .word_in(tx_head), .miso(miso),
        .take(take), .done(done), .rx_word(rx_word), .busy(busy),
        .sck(sck), .mosi(mosi)
    );

    // interrupt events; mode-fault, slave-fault and underrun sources cannot occur here
    always_comb begin
        ev            = '0;
        ev[I_TXEMPTY] = done && !take && tx_empty;
        ev[I_RXFULL]  = done && !rx_pop && (rx_level == RX_NEAR);
        ev[I_RXOVR]   = done && !rx_pop && rx_full;
        ev[I_TXHALF]  = take && !tx_push && (tx_level == TX_MID);
    end

    always_comb begin
        regs_d = regs_q;
        if (wr_ctrl) begin
            regs_d.ctrl          = bus_wdata[NCTRL-1:0];
            regs_d.ctrl[C_TXRST] = 1'b0;
            regs_d.ctrl[C_RXRST] = 1'b0;
        end
        if (bus_wr && bus_addr == A_SSEL) regs_d.ss  = bus_wdata[NSS-1:0];
        if (bus_wr && bus_addr == A_GIE)  regs_d.gie = bus_wdata[31];
        if (bus_wr && bus_addr == A_IER)  regs_d.ier = bus_wdata[NIRQ-1:0];
        if (bus_wr && bus_addr == A_ISR)  regs_d.isr = regs_q.isr & ~bus_wdata[NIRQ-1:0];
        regs_d.isr = regs_d.isr | ev;
        if (soft_rst) regs_d = REGS_RST;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= REGS_RST;
        else        regs_q <= regs_d;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL: bus_rdata = 32'(regs_q.ctrl);
            A_STAT: bus_rdata = {27'd0, 1'b0, tx_full, tx_empty, rx_full, rx_empty};
            A_RXD:  bus_rdata = rx_empty ? '0 : 32'(rx_head);
            A_SSEL: bus_rdata = 32'(regs_q.ss);
            A_GIE:  bus_rdata = {regs_q.gie, 31'd0};
            A_ISR:  bus_rdata = 32'(regs_q.isr);
            A_IER:  bus_rdata = 32'(regs_q.ier);
            default: bus_rdata = '0;
        endcase
    end

    assign irq  = regs_q.gie && |(regs_q.isr & regs_q.ier);
    assign ss_n = regs_q.ss;
endmodule

// File: rtl/mmspi_chk.sv
module mmspi_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       irq,
    input logic       gie,
    input logic       inh,
    input logic       busy,
    input logic [6:0] isr,
    input logic [9:0] ctrl,
    input logic       tx_empty,
    input logic       rx_full,
    input logic       tx_clr,
    input logic       soft_rst
);
    // R12
    a_r12_irq_needs_gate: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> gie);
    a_r12_irq_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (isr != 7'd0));
    // R4
    a_r4_hold_keeps_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (inh && !busy) |=> !busy);
    // R11
    a_r11_txempty_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(isr[2]) |-> tx_empty);
    a_r11_overrun_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(isr[5]) |-> rx_full);
    // R10
    a_r10_tx_flush: assert property (@(posedge clk) disable iff (!rst_n)
        tx_clr |=> tx_empty);
    // R2
    a_r2_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (ctrl == 10'd0 && !busy && isr == 7'd0 && !gie));
endmodule

bind mmspi_master mmspi_chk u_chk (
    .clk(clk), .rst_n(rst_n), .irq(irq), .gie(regs_q.gie),
    .inh(regs_q.ctrl[8]), .busy(busy), .isr(regs_q.isr), .ctrl(regs_q.ctrl),
    .tx_empty(tx_empty), .rx_full(rx_full), .tx_clr(tx_clr), .soft_rst(soft_rst)
);

// File: tb/test_mmspi_master.sv
module test_mmspi_master;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8, DEPTH = 4, HALF_DIV = 2, NSS = 2;
    localparam int WORD_CYC = 2 * W * HALF_DIV;

    localparam logic [7:0] R_GIE = 8'h1C, R_ISR = 8'h20, R_IER = 8'h28, R_SRST = 8'h40,
                           R_CTRL = 8'h60, R_STAT = 8'h64, R_TXD = 8'h68, R_RXD = 8'h6C,
                           R_SSEL = 8'h70;
    localparam logic [31:0] K_LOOP = 32'h1, K_EN = 32'h2, K_MST = 32'h4, K_CPOL = 32'h8,
                            K_CPHA = 32'h10, K_TXRST = 32'h20, K_RXRST = 32'h40,
                            K_INH = 32'h100, K_LSB = 32'h200;

    logic clk = 1'b0, rst_n = 1'b0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_addr = 8'h0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic irq, sck, mosi;
    logic [NSS-1:0] ss_n;

    int checks = 0, errors = 0;
    bit finished = 1'b0;

    // slave model
    logic [7:0] s_tx = 8'hFF, s_rx = 8'h00;
    logic s_cpol = 1'b0, s_cpha = 1'b0, s_on = 1'b0;
    int s_edges = 0, sck_toggles = 0;
    wire miso = s_tx[7];

    mmspi_master #(.W(W), .DEPTH(DEPTH), .HALF_DIV(HALF_DIV), .NSS(NSS)) i_mmspi_master (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .sck(sck), .mosi(mosi),
        .miso(miso), .ss_n(ss_n)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(sck) begin
        if (rst_n) sck_toggles++;
        if (s_on) begin
            if ((sck != s_cpol) ^ s_cpha) s_rx = {s_rx[6:0], mosi};
            else if (s_edges != 0)        s_tx = {s_tx[6:0], 1'b0};
            s_edges++;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic peek(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b0;
        #1 v = bus_rdata;
    endtask

    task automatic pop_rx(output logic [31:0] v);
        @(negedge clk);
        bus_addr = R_RXD; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    function automatic logic [7:0] rev8(input logic [7:0] v);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = v[7 - i];
        return r;
    endfunction

    function automatic logic [31:0] mode_of(input int c);
        return (c[0] ? K_CPOL : 32'h0) | (c[1] ? K_CPHA : 32'h0) | (c[2] ? K_LSB : 32'h0);
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [7:0] sent [DEPTH];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        peek(R_STAT, v);  chk(v == 32'h05, "R1 status", v, 32'h05);
        peek(R_CTRL, v);  chk(v == 32'h0, "R1 control", v, 32'h0);
        chk(ss_n == 2'b11, "R1 ss_n", 32'(ss_n), 32'h3);
        chk(irq == 1'b0 && sck == 1'b0, "R1 irq/sck", {30'd0, irq, sck}, 32'h0);
        pop_rx(v);        chk(v == 32'h0, "R13 empty read", v, 32'h0);

        // R9 slave select
        wr(R_SSEL, 32'h2); chk(ss_n == 2'b10, "R9 select line0", 32'(ss_n), 32'h2);
        wr(R_SSEL, 32'h1); chk(ss_n == 2'b01, "R9 select line1", 32'(ss_n), 32'h1);
        wr(R_SSEL, 32'h3); chk(ss_n == 2'b11, "R9 deselect", 32'(ss_n), 32'h3);

        // R4 enable/master gating: enable clear, master set
        wr(R_CTRL, K_MST);
        sck_toggles = 0;
        wr(R_TXD, 32'h5A);
        repeat (WORD_CYC + 4) @(negedge clk);
        chk(sck_toggles == 0, "R4 no sck without enable", sck_toggles, 0);
        peek(R_STAT, v); chk(v[2] == 1'b0, "R4 word still queued", v, 32'h0);
        wr(R_CTRL, K_MST | K_TXRST);
        peek(R_STAT, v); chk(v[2] == 1'b1, "R10 tx flush", v, 32'h4);
        peek(R_CTRL, v); chk(v == K_MST, "R10 reset bit self-clears", v, K_MST);

        // R3 R4 R5 R8 R11 R13: loopback sweep over all modes
        for (int c = 0; c < 8; c++) begin
            logic [31:0] base;
            int n;
            base = K_EN | K_MST | K_LOOP | mode_of(c);
            s_tx = 8'hFF;                       // miso held high: must be ignored
            wr(R_CTRL, base | K_INH);
            wr(R_ISR, 32'h7F);
            sck_toggles = 0;
            for (int i = 0; i < DEPTH; i++) begin
                peek(R_STAT, v);
                chk(v[3] == 1'b0, "R3 not full early", v, 32'h0);
                sent[i] = 8'(c * 53 + i * 71 + 17);
                wr(R_TXD, 32'(sent[i]));
            end
            peek(R_STAT, v); chk(v[3] == 1'b1, "R3 full at depth", v, 32'h8);
            repeat (WORD_CYC) @(negedge clk);
            chk(sck_toggles == 0, "R4 hold keeps sck idle", sck_toggles, 0);
            chk(sck == c[0], "R6 idle level", 32'(sck), 32'(c[0]));
            wr(R_CTRL, base);
            bus_addr = R_ISR;
            n = 0;
            while (n < 1000) begin
                @(negedge clk); n++;
                #1;
                if (bus_rdata[2]) break;
            end
            chk(n == 1 + DEPTH * WORD_CYC, "R5 burst length", n, 1 + DEPTH * WORD_CYC);
            chk(sck_toggles == 2 * W * DEPTH, "R5 sck edges", sck_toggles, 2 * W * DEPTH);
            peek(R_ISR, v);
            chk(v[6] && v[4], "R11 half-empty and rx-full set", v, 32'h54);
            for (int i = 0; i < DEPTH; i++) begin
                pop_rx(v);
                chk(v == 32'(sent[i]), "R8 R13 loopback word order", v, 32'(sent[i]));
            end
            peek(R_STAT, v); chk(v[0] == 1'b1, "R13 rx drained", v, 32'h1);
        end

        // R6 R7: external slave, all modes, no loopback
        for (int c = 0; c < 8; c++) begin
            for (int k = 0; k < 2; k++) begin
                logic [7:0] mw, sw;
                mw = 8'(8'hA5 ^ (c * 37 + k * 91));
                sw = 8'(c * 29 + k * 113 + 3);
                s_on = 1'b0;
                wr(R_CTRL, K_EN | K_MST | mode_of(c));
                s_cpol = c[0]; s_cpha = c[1];
                s_tx = sw; s_rx = 8'h00; s_edges = 0;
                s_on = 1'b1;
                wr(R_TXD, 32'(mw));
                repeat (WORD_CYC + 6) @(negedge clk);
                s_on = 1'b0;
                pop_rx(v);
                chk(v == 32'(c[2] ? rev8(sw) : sw), "R6 R7 master received", v, 32'(c[2] ? rev8(sw) : sw));
                chk(s_rx == (c[2] ? rev8(mw) : mw), "R6 R7 slave received", 32'(s_rx), 32'(c[2] ? rev8(mw) : mw));
                chk(sck == c[0], "R6 idle after word", 32'(sck), 32'(c[0]));
            end
        end

        // R11 overrun, R10 rx flush
        wr(R_CTRL, K_EN | K_MST | K_LOOP);
        wr(R_ISR, 32'h7F);
        for (int i = 0; i < DEPTH; i++) begin
            sent[i] = 8'(i * 19 + 6);
            wr(R_TXD, 32'(sent[i]));
        end
        repeat (DEPTH * WORD_CYC + 8) @(negedge clk);
        peek(R_ISR, v); chk(v[4] && !v[5], "R11 rx full no overrun", v, 32'h10);
        wr(R_TXD, 32'hEE);
        repeat (WORD_CYC + 8) @(negedge clk);
        peek(R_ISR, v); chk(v[5] == 1'b1, "R11 overrun set", v, 32'h20);
        peek(R_STAT, v); chk(v[1] == 1'b1, "R11 rx full flag", v, 32'h2);
        pop_rx(v); chk(v == 32'(sent[0]), "R11 dropped word not kept", v, 32'(sent[0]));
        wr(R_CTRL, K_EN | K_MST | K_LOOP | K_RXRST);
        peek(R_STAT, v); chk(v[0] == 1'b1, "R10 rx flush", v, 32'h1);

        // R12 interrupt gating, R11 write-one-to-clear
        peek(R_ISR, v); chk(v[2] == 1'b1, "R11 tx empty sticky", v, 32'h4);
        wr(R_IER, 32'h4);
        chk(irq == 1'b0, "R12 no irq without gate", 32'(irq), 32'h0);
        wr(R_GIE, 32'h8000_0000);
        chk(irq == 1'b1, "R12 irq with gate", 32'(irq), 32'h1);
        wr(R_IER, 32'h0);
        chk(irq == 1'b0, "R12 no irq when disabled", 32'(irq), 32'h0);
        wr(R_IER, 32'h4);
        wr(R_ISR, 32'h4);
        peek(R_ISR, v); chk(v[2] == 1'b0, "R11 bit cleared", v, 32'h0);
        chk(irq == 1'b0, "R12 irq drops after clear", 32'(irq), 32'h0);

        // R2 keyed reset
        wr(R_SSEL, 32'h2);
        wr(R_CTRL, K_EN | K_MST | K_INH);
        wr(R_TXD, 32'h33);
        wr(R_SRST, 32'h5);
        peek(R_CTRL, v); chk(v == (K_EN | K_MST | K_INH), "R2 wrong key ignored", v, K_EN | K_MST | K_INH);
        chk(ss_n == 2'b10, "R2 wrong key keeps select", 32'(ss_n), 32'h2);
        wr(R_SRST, 32'hA);
        peek(R_CTRL, v); chk(v == 32'h0, "R2 control cleared", v, 32'h0);
        peek(R_STAT, v); chk(v == 32'h05, "R2 status reset", v, 32'h05);
        peek(R_GIE, v);  chk(v == 32'h0, "R2 gate cleared", v, 32'h0);
        chk(ss_n == 2'b11, "R2 select reset", 32'(ss_n), 32'h3);

        finished = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule